// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block turns one burst request into the column addresses of its data beats. A single-cycle start pulse carries a starting column, a burst length code and a burst order. From the next cycle on, the block emits one column per cycle, with a valid flag on every beat and a last flag on the final beat. Only the low bits inside an aligned block the size of the burst take part in the walk. The column bits above that block keep the starting value for the whole burst.

Two orders are supported. In the sequential order the low bits count up from the start and wrap inside the block. In the interleaved order the low bits are the start low bits XOR the beat number. The block sits between a command scheduler, which supplies the start pulse, and the column path of the array, which takes one address per beat. DDR beat clocking happens elsewhere: one output step is one beat.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, last_o and err_o are all 0.
- R2: The length code blen_i maps as follows: 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats. When a start is accepted at a clock edge, the first beat appears after that edge with col_o equal to the starting column. The beats then follow on consecutive cycles, one beat per cycle, and their number equals the burst length.
- R3: When btype_i is 0 (sequential), the block bits of beat k are (start low bits + k) modulo the length. For example, a length-8 burst from 5 gives 5,6,7,0,1,2,3,4.
- R4: When btype_i is 1 (interleaved), the block bits of beat k are the start low bits XOR k. For example, a length-8 burst from 3 gives 3,2,1,0,7,6,5,4.
- R5: In every beat, the column bits above the burst block equal those of the starting column. There is no carry out of the block.
- R6: For length 2, both orders give the same result: a start of 0 gives 0,1 and a start of 1 gives 1,0.
- R7: last_o is 1 on the final beat of a burst and 0 on every other cycle.
- R8: After the final beat, valid_o is 0 on the next cycle, unless a start was presented during the final beat. In that case the new burst's first beat follows with no gap.
- R9: A start presented during a burst, on any beat but the last, is ignored. Length, order and starting column stay as captured.
- R10: The length code 2'b00 is illegal. A start with this code issues no beats, and err_o is 1 for exactly the one cycle after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Length code: 01=2, 10=4, 11=8, 00 illegal |
| btype_i | input | 1 | Order: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | One-cycle pulse after an illegal start |

## Verification
The bench builds the block with COL_W set to 7. That leaves four bits above the largest burst block, so any carry out of the walk shows up in the fixed upper bits. Random starting columns reach every block offset and every upper-bit pattern across all three lengths and both orders. Directed cases pin down the two worked examples and both length-2 starts. Further directed cases cover a chained start on the final beat, starts injected in the middle of a burst, and the illegal length code.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    BL_BAD = 2'b00,
    BL_2   = 2'b01,
    BL_4   = 2'b10,
    BL_8   = 2'b11
  } blen_e;

  localparam int unsigned BEAT_W = 3;

  // mask of the low column bits that walk; also equals beats-1
  function automatic logic [BEAT_W-1:0] beat_mask(input logic [1:0] enc);
    case (enc)
      BL_2:    beat_mask = 3'b001;
      BL_4:    beat_mask = 3'b011;
      BL_8:    beat_mask = 3'b111;
      default: beat_mask = 3'b000;
    endcase
  endfunction

  function automatic logic len_legal(input logic [1:0] enc);
    len_legal = (enc != BL_BAD);
  endfunction

  // block-internal bits of one beat
  function automatic logic [BEAT_W-1:0] walk_bits(input logic [BEAT_W-1:0] s,
                                                  input logic [BEAT_W-1:0] k,
                                                  input logic              il,
                                                  input logic [BEAT_W-1:0] m);
    walk_bits = il ? ((s ^ k) & m) : ((s + k) & m);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [1:0]        blen_i,
  input  logic              btype_i,
  output logic              busy_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [COL_W-1:0]  base_col_o,
  output logic [1:0]        enc_o,
  output logic              il_o,
  output logic              last_o,
  output logic              err_o
);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic [COL_W-1:0]  base_q;
  logic [1:0]        enc_q;
  logic              il_q;
  logic              err_q;

  logic at_last;
  logic accept;
  logic accept_ok;
  logic accept_bad;

  assign at_last    = busy_q && (beat_q == beat_mask(enc_q));
  assign accept     = start_i && (!busy_q || at_last);
  assign accept_ok  = accept && len_legal(blen_i);
  assign accept_bad = accept && !len_legal(blen_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      enc_q  <= BL_BAD;
      il_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept_bad;
      if (accept_ok) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        base_q <= start_col_i;
        enc_q  <= blen_i;
        il_q   <= btype_i;
      end else if (at_last) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else if (busy_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign beat_o     = beat_q;
  assign base_col_o = base_q;
  assign enc_o      = enc_q;
  assign il_o       = il_q;
  assign last_o     = at_last;
  assign err_o      = err_q;

  // beat counter never leaves the burst length (R2)
  assert_beat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (beat_q <= beat_mask(enc_q)));

  // captured request is frozen until the final beat (R9)
  assert_hold_params_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> ($stable(base_q) && $stable(enc_q) && $stable(il_q)));

  // an illegal start never launches a burst (R10)
  assert_bad_no_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_bad && !busy_q) |=> !busy_q);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_col_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [1:0]        enc_i,
  input  logic              il_i,
  output logic [COL_W-1:0]  col_o
);

  localparam int unsigned UP_W = COL_W - BEAT_W;

  logic [BEAT_W-1:0] m3;
  logic [BEAT_W-1:0] low3;
  logic [COL_W-1:0]  m_full;
  logic [COL_W-1:0]  low_full;

  assign m3       = beat_mask(enc_i);
  assign low3     = walk_bits(base_col_i[BEAT_W-1:0], beat_i, il_i, m3);
  assign m_full   = {{UP_W{1'b0}}, m3};
  assign low_full = {{UP_W{1'b0}}, low3};
  assign col_o    = (base_col_i & ~m_full) | low_full;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             btype_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic              busy_w;
  logic [BEAT_W-1:0] beat_w;
  logic [COL_W-1:0]  base_w;
  logic [1:0]        enc_w;
  logic              il_w;
  logic              last_w;
  logic              err_w;

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .btype_i     (btype_i),
    .busy_o      (busy_w),
    .beat_o      (beat_w),
    .base_col_o  (base_w),
    .enc_o       (enc_w),
    .il_o        (il_w),
    .last_o      (last_w),
    .err_o       (err_w)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_col_i (base_w),
    .beat_i     (beat_w),
    .enc_i      (enc_w),
    .il_i       (il_w),
    .col_o      (col_o)
  );

  assign valid_o = busy_w;
  assign last_o  = last_w;
  assign err_o   = err_w;

  assert_last_has_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  assert_err_no_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(start_i));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> (col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W])));

endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

  localparam int W     = 7;
  localparam int TCLK  = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] start_col_i = '0;
  logic [1:0]   blen_i = 2'b00;
  logic         btype_i = 1'b0;
  logic [W-1:0] col_o;
  logic         valid_o, last_o, err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  burst_col_seq #(.COL_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .btype_i(btype_i), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o), .err_o(err_o)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic int beats_of(input logic [1:0] e);
    return (e == 2'b01) ? 2 : (e == 2'b10) ? 4 : (e == 2'b11) ? 8 : 0;
  endfunction

  function automatic int exp_col(input int c, input logic [1:0] e, input bit t, input int k);
    int n, off, lo;
    n   = beats_of(e);
    off = c % n;
    lo  = t ? (off ^ k) : ((off + k) % n);
    return c - off + lo;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic present(input int c, input logic [1:0] e, input bit t);
    start_i = 1'b1; start_col_i = W'(c); blen_i = e; btype_i = t;
  endtask

  // at a negedge showing beat 0 of an accepted burst
  task automatic walk(input int c, input logic [1:0] e, input bit t, input bit noise,
                      input bit chain, input int nc, input logic [1:0] ne, input bit nt);
    int n;
    n = beats_of(e);
    for (int k = 0; k < n; k++) begin
      check(valid_o === 1'b1, "R2 valid", valid_o, 1);
      check(col_o === W'(exp_col(c, e, t, k)), t ? "R4 order" : "R3 order",
            col_o, exp_col(c, e, t, k));
      check((col_o >> 3) === W'(c >> 3), "R5 upper", col_o >> 3, c >> 3);
      check(last_o === (k == n-1), "R7 last", last_o, k == n-1);
      if (noise && k < n-1)
        present($urandom % (1 << W), 2'($urandom % 4), 1'($urandom % 2)); // R9
      if (chain && k == n-1) present(nc, ne, nt);
      @(negedge clk);
      start_i = 1'b0;
    end
    if (!chain) begin
      check(valid_o === 1'b0, "R8 idle", valid_o, 0);
      check(last_o === 1'b0, "R7 idle last", last_o, 0);
    end
  endtask

  task automatic burst(input int c, input logic [1:0] e, input bit t, input bit noise);
    present(c, e, t);
    @(negedge clk);
    start_i = 1'b0;
    walk(c, e, t, noise, 1'b0, 0, 2'b00, 1'b0);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(77);
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0 && err_o === 1'b0, "R1 reset",
          {valid_o, last_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0, "R1 after reset", valid_o, 0);

    burst(7'h05, 2'b11, 1'b0, 1'b0);   // R3 5,6,7,0,1,2,3,4
    burst(7'h03, 2'b11, 1'b1, 1'b0);   // R4 3,2,1,0,7,6,5,4
    burst(7'h50, 2'b01, 1'b0, 1'b0);   // R6 0,1
    burst(7'h50, 2'b01, 1'b1, 1'b0);
    burst(7'h51, 2'b01, 1'b0, 1'b0);   // R6 1,0
    burst(7'h51, 2'b01, 1'b1, 1'b0);
    burst(7'h7F, 2'b10, 1'b0, 1'b0);   // R5 no carry from top of block
    burst(7'h2E, 2'b11, 1'b0, 1'b1);   // R9 mid-burst starts ignored
    burst(7'h13, 2'b10, 1'b1, 1'b1);

    // R8 chained start during last beat
    present(7'h21, 2'b10, 1'b0);
    @(negedge clk); start_i = 1'b0;
    walk(7'h21, 2'b10, 1'b0, 1'b0, 1'b1, 7'h46, 2'b11, 1'b1);
    walk(7'h46, 2'b11, 1'b1, 1'b0, 1'b0, 0, 2'b00, 1'b0);

    // R10 illegal length code
    present(7'h0A, 2'b00, 1'b0);
    @(negedge clk); start_i = 1'b0;
    check(err_o === 1'b1, "R10 err pulse", err_o, 1);
    check(valid_o === 1'b0, "R10 no beat", valid_o, 0);
    @(negedge clk);
    check(err_o === 1'b0, "R10 err one cycle", err_o, 0);
    check(valid_o === 1'b0, "R10 still idle", valid_o, 0);

    // R10 illegal chained on last beat
    present(7'h30, 2'b01, 1'b0);
    @(negedge clk); start_i = 1'b0;
    walk(7'h30, 2'b01, 1'b0, 1'b0, 1'b1, 7'h0, 2'b00, 1'b0);
    check(err_o === 1'b1 && valid_o === 1'b0, "R10 chained illegal", {err_o, valid_o}, 2);
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] e;
      e = 2'(1 + ($urandom % 3));
      burst($urandom % (1 << W), e, 1'($urandom % 2), ($urandom % 4) == 0);
      if ($urandom % 2) @(negedge clk);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule